// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps wall-clock time for a chip that already produces a one-pulse-per-second tick. Seconds, minutes and hours are held as packed BCD bytes. Elapsed whole days are held as a 15-bit binary count, and software turns that count into a date. Software reads and writes every field through byte-wide registers on a simple address/data bus. Writes take effect on the clock edge that samples them. Reads are combinational from the address.

An alarm compares the current minute, hour and day against three programmed values. Each field has its own match enable. When the alarm fires it sets a sticky flag, and software clears the flag by writing a one to its bit. The interrupt request is the flag gated by an interrupt enable.

The sequencer has two named states. ST_IDLE is the resting state. It moves to ST_STEP when a tick is sampled while the run enable is set. ST_STEP lasts one cycle and always returns to ST_IDLE. During ST_STEP the busy bit reads 1. On the edge that leaves ST_STEP, every counter takes its next value and the alarm is evaluated.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds (address 0x15) count BCD 0x00 to 0x59. On a step at 0x59 they return to 0x00 and carry into minutes.
- R2: Minutes (0x16) count BCD 0x00 to 0x59 and carry into hours at 0x59. Hours (0x17) count BCD 0x00 to 0x23 and carry into days at 0x23.
- R3: The day count is 15-bit binary. Its low byte is at 0x18 and bits 14..8 are at 0x19, which reads 0 in bit 7. A carry at 0x7FFF wraps the count to 0.
- R4: Control register 0x14, bit 0 is the run enable. With bit 0 clear, ticks leave every time field unchanged.
- R5: Control bit 7 is the read-only busy bit. A tick sampled while running makes busy read 1 for exactly the next cycle. The advanced time is readable from the cycle after that.
- R6: A write to 0x15 to 0x19 loads that field exactly as written, including out-of-range BCD values. A write to these addresses is ignored while busy is 1.
- R7: The alarm registers are minute 0x1A, hour 0x1B, day low 0x1C and day high 0x1D. The match enables are control bit 3 (minute), bit 4 (hour) and bit 5 (day). The alarm flag, control bit 2, is set on the step at which all enabled fields first equal the time. A field whose enable is clear counts as matching. A step that leaves an already-matching time still matching does not set the flag.
- R8: With control bits 5, 4 and 3 all clear, the alarm flag is never set.
- R9: Writing control with bit 2 = 1 clears the flag, and bit 2 = 0 leaves the flag as it is. If the flag is set and cleared on the same edge, the set wins.
- R10: The output irq is high exactly when the alarm flag is 1 and control bit 1 (the interrupt enable) is 1.
- R11: After reset, every register reads 0x00 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Alarm interrupt request |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- The full 23:59:59 rollover, together with the day wrap from 0x7FFF. A wrong limit or carry chain would show a time such as 0x60 seconds or 0x24 hours, or a day count that sticks or overflows.
- A write that lands in the busy cycle. A missing guard would let the write overwrite the freshly advanced second.
- A set and a clear of the alarm flag on the same edge. The wrong priority would lose an alarm.
- Ticks that keep an already-matching time matching, and an alarm with no field enabled. A level-sensitive alarm would fire again after every clear, and a design that treats "nothing enabled" as a match would raise the flag on every step.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BUS_W = 8;

    localparam logic [BUS_W-1:0] A_CTRL   = 8'h14;
    localparam logic [BUS_W-1:0] A_SEC    = 8'h15;
    localparam logic [BUS_W-1:0] A_MIN    = 8'h16;
    localparam logic [BUS_W-1:0] A_HOUR   = 8'h17;
    localparam logic [BUS_W-1:0] A_DAYL   = 8'h18;
    localparam logic [BUS_W-1:0] A_DAYH   = 8'h19;
    localparam logic [BUS_W-1:0] A_AMIN   = 8'h1A;
    localparam logic [BUS_W-1:0] A_AHOUR  = 8'h1B;
    localparam logic [BUS_W-1:0] A_ADAYL  = 8'h1C;
    localparam logic [BUS_W-1:0] A_ADAYH  = 8'h1D;

    localparam int B_BUSY = 7;
    localparam int B_DEN  = 5;
    localparam int B_HEN  = 4;
    localparam int B_MEN  = 3;
    localparam int B_FLAG = 2;
    localparam int B_AIEN = 1;
    localparam int B_RUN  = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_STEP = 1'b1
    } cal_state_e;

    typedef struct packed {
        logic den;
        logic hen;
        logic men;
        logic aien;
        logic run;
    } cal_ctrl_t;

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
    parameter logic [7:0] LIMIT = 8'h59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carry_in,
    input  logic       advance,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] value,
    output logic [7:0] next_val,
    output logic       carry_out
);

    logic [7:0] val_q;
    logic [7:0] inc;

    always_comb begin
        if (val_q[3:0] >= 4'd9) begin
            inc = {val_q[7:4] + 4'd1, 4'd0};
        end else begin
            inc = {val_q[7:4], val_q[3:0] + 4'd1};
        end
    end

    assign carry_out = carry_in && (val_q == LIMIT);
    assign next_val  = !carry_in ? val_q : ((val_q == LIMIT) ? 8'h00 : inc);
    assign value     = val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= 8'h00;
        end else if (advance) begin
            val_q <= next_val;
        end else if (load) begin
            val_q <= load_val;
        end
    end

    // R1 (and R2 for the minute and hour instances): wrap at the limit
    assert_bcd_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && carry_in && val_q == LIMIT) |=> (val_q == 8'h00));

    assert_field_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(val_q));

endmodule

// File: rtl/rtc_day_counter.sv
module rtc_day_counter #(
    parameter int DAY_W = 15,
    localparam int HI_W = DAY_W - 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry_in,
    input  logic             advance,
    input  logic             load_lo,
    input  logic             load_hi,
    input  logic [7:0]       lo_val,
    input  logic [HI_W-1:0]  hi_val,
    output logic [DAY_W-1:0] value,
    output logic [DAY_W-1:0] next_val
);

    logic [DAY_W-1:0] day_q;

    assign next_val = carry_in ? day_q + 1'b1 : day_q;
    assign value    = day_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            day_q <= '0;
        end else if (advance) begin
            day_q <= next_val;
        end else begin
            if (load_lo) day_q[7:0]       <= lo_val;
            if (load_hi) day_q[DAY_W-1:8] <= hi_val;
        end
    end

    assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && carry_in && (&day_q)) |=> (day_q == '0));

endmodule

// File: rtl/rtc_alarm_eval.sv
module rtc_alarm_eval #(
    parameter int DAY_W = 15
) (
    input  logic [7:0]       cur_min,
    input  logic [7:0]       cur_hour,
    input  logic [DAY_W-1:0] cur_day,
    input  logic [7:0]       nxt_min,
    input  logic [7:0]       nxt_hour,
    input  logic [DAY_W-1:0] nxt_day,
    input  logic [7:0]       al_min,
    input  logic [7:0]       al_hour,
    input  logic [DAY_W-1:0] al_day,
    input  logic             men,
    input  logic             hen,
    input  logic             den,
    output logic             hit
);

    logic any_en;
    logic cur_match;
    logic nxt_match;

    assign any_en = men || hen || den;

    always_comb begin
        cur_match = any_en
                 && (!men || cur_min  == al_min)
                 && (!hen || cur_hour == al_hour)
                 && (!den || cur_day  == al_day);
        nxt_match = any_en
                 && (!men || nxt_min  == al_min)
                 && (!hen || nxt_hour == al_hour)
                 && (!den || nxt_day  == al_day);
    end

    // fire only on the step that enters the matching time
    assign hit = nxt_match && !cur_match;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int DAY_W = 15,
    localparam int HI_W = DAY_W - 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    cal_state_e state_q, state_d;
    cal_ctrl_t  ctrl_q;
    logic       flag_q;
    logic       busy;
    logic       time_wr_ok;
    logic       hit;

    logic [7:0]       sec_v, sec_n, min_v, min_n, hour_v, hour_n;
    logic             sec_c, min_c, hour_c;
    logic [DAY_W-1:0] day_v, day_n;
    logic [7:0]       amin_q, ahour_q;
    logic [DAY_W-1:0] aday_q;

    // ---- sequencer: state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick && ctrl_q.run) state_d = ST_STEP;
            ST_STEP: state_d = ST_IDLE;
        endcase
    end

    // ---- sequencer: outputs ----
    always_comb begin
        busy       = (state_q == ST_STEP);
        time_wr_ok = bus_wr && !busy;
        irq        = flag_q && ctrl_q.aien;
    end

    // ---- time fields ----
    rtc_bcd_field #(.LIMIT(8'h59)) u_sec (
        .clk(clk), .rst_n(rst_n), .carry_in(1'b1), .advance(busy),
        .load(time_wr_ok && bus_addr == A_SEC), .load_val(bus_wdata),
        .value(sec_v), .next_val(sec_n), .carry_out(sec_c));

    rtc_bcd_field #(.LIMIT(8'h59)) u_min (
        .clk(clk), .rst_n(rst_n), .carry_in(sec_c), .advance(busy),
        .load(time_wr_ok && bus_addr == A_MIN), .load_val(bus_wdata),
        .value(min_v), .next_val(min_n), .carry_out(min_c));

    rtc_bcd_field #(.LIMIT(8'h23)) u_hour (
        .clk(clk), .rst_n(rst_n), .carry_in(min_c), .advance(busy),
        .load(time_wr_ok && bus_addr == A_HOUR), .load_val(bus_wdata),
        .value(hour_v), .next_val(hour_n), .carry_out(hour_c));

    rtc_day_counter #(.DAY_W(DAY_W)) u_day (
        .clk(clk), .rst_n(rst_n), .carry_in(hour_c), .advance(busy),
        .load_lo(time_wr_ok && bus_addr == A_DAYL),
        .load_hi(time_wr_ok && bus_addr == A_DAYH),
        .lo_val(bus_wdata), .hi_val(bus_wdata[HI_W-1:0]),
        .value(day_v), .next_val(day_n));

    // ---- alarm compare ----
    rtc_alarm_eval #(.DAY_W(DAY_W)) u_alarm (
        .cur_min(min_v), .cur_hour(hour_v), .cur_day(day_v),
        .nxt_min(min_n), .nxt_hour(hour_n), .nxt_day(day_n),
        .al_min(amin_q), .al_hour(ahour_q), .al_day(aday_q),
        .men(ctrl_q.men), .hen(ctrl_q.hen), .den(ctrl_q.den),
        .hit(hit));

    // ---- control and alarm registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            flag_q  <= 1'b0;
            amin_q  <= 8'h00;
            ahour_q <= 8'h00;
            aday_q  <= '0;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    A_CTRL: begin
                        ctrl_q.den  <= bus_wdata[B_DEN];
                        ctrl_q.hen  <= bus_wdata[B_HEN];
                        ctrl_q.men  <= bus_wdata[B_MEN];
                        ctrl_q.aien <= bus_wdata[B_AIEN];
                        ctrl_q.run  <= bus_wdata[B_RUN];
                    end
                    A_AMIN:  amin_q  <= bus_wdata;
                    A_AHOUR: ahour_q <= bus_wdata;
                    A_ADAYL: aday_q[7:0]       <= bus_wdata;
                    A_ADAYH: aday_q[DAY_W-1:8] <= bus_wdata[HI_W-1:0];
                    default: ;
                endcase
            end
            if (busy && hit) begin
                flag_q <= 1'b1;
            end else if (bus_wr && bus_addr == A_CTRL && bus_wdata[B_FLAG]) begin
                flag_q <= 1'b0;
            end
        end
    end

    // ---- read mux ----
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {busy, 1'b0, ctrl_q.den, ctrl_q.hen, ctrl_q.men,
                                  flag_q, ctrl_q.aien, ctrl_q.run};
            A_SEC:   bus_rdata = sec_v;
            A_MIN:   bus_rdata = min_v;
            A_HOUR:  bus_rdata = hour_v;
            A_DAYL:  bus_rdata = day_v[7:0];
            A_DAYH:  bus_rdata = {{(8-HI_W){1'b0}}, day_v[DAY_W-1:8]};
            A_AMIN:  bus_rdata = amin_q;
            A_AHOUR: bus_rdata = ahour_q;
            A_ADAYL: bus_rdata = aday_q[7:0];
            A_ADAYH: bus_rdata = {{(8-HI_W){1'b0}}, aday_q[DAY_W-1:8]};
            default: bus_rdata = 8'h00;
        endcase
    end

    // ---- assertions ----
    assert_busy_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_busy_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick && ctrl_q.run) |=> busy);

    assert_time_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == A_SEC) |=> (sec_v == $past(sec_n)));

    assert_flag_rise_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(busy));

    assert_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.men && !ctrl_q.hen && !ctrl_q.den && !flag_q) |=> !flag_q);

    assert_flag_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr == A_CTRL && bus_wdata[B_FLAG]) |=> !flag_q);

endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq));

    // ---------------- reference model ----------------
    int m_sec, m_min, m_hr, m_day, m_amin, m_ahr, m_aday;
    bit m_run, m_aien, m_men, m_hen, m_den, m_flag, m_step;

    function automatic int bcd_up(int v);
        int lo = v % 16;
        int hi = v / 16;
        if (lo >= 9) begin lo = 0; hi = (hi + 1) % 16; end
        else lo = lo + 1;
        return hi * 16 + lo;
    endfunction

    function automatic bit alarm_eq(int mn, int hr, int dy);
        if (!(m_men || m_hen || m_den)) return 1'b0;
        if (m_men && mn != m_amin) return 1'b0;
        if (m_hen && hr != m_ahr) return 1'b0;
        if (m_den && dy != m_aday) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int model_rd(logic [7:0] a);
        case (a)
            8'h14: return (m_step ? 128 : 0) + (m_den ? 32 : 0) + (m_hen ? 16 : 0)
                        + (m_men ? 8 : 0) + (m_flag ? 4 : 0) + (m_aien ? 2 : 0)
                        + (m_run ? 1 : 0);
            8'h15: return m_sec;
            8'h16: return m_min;
            8'h17: return m_hr;
            8'h18: return m_day % 256;
            8'h19: return m_day / 256;
            8'h1A: return m_amin;
            8'h1B: return m_ahr;
            8'h1C: return m_aday % 256;
            8'h1D: return m_aday / 256;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 0;
            m_amin = 0; m_ahr = 0; m_aday = 0;
            m_run = 0; m_aien = 0; m_men = 0; m_hen = 0; m_den = 0;
            m_flag = 0; m_step = 0;
        end else begin
            automatic bit was = m_step;
            automatic bit fire = 1'b0;
            if (was) begin
                automatic int ns = (m_sec == 'h59) ? 0 : bcd_up(m_sec);
                automatic int nm = m_min, nh = m_hr, nd = m_day;
                if (m_sec == 'h59) begin
                    nm = (m_min == 'h59) ? 0 : bcd_up(m_min);
                    if (m_min == 'h59) begin
                        nh = (m_hr == 'h23) ? 0 : bcd_up(m_hr);
                        if (m_hr == 'h23) nd = (m_day + 1) % 32768;
                    end
                end
                fire = alarm_eq(nm, nh, nd) && !alarm_eq(m_min, m_hr, m_day);
                m_sec = ns; m_min = nm; m_hr = nh; m_day = nd;
                if (fire) m_flag = 1'b1;
                m_step = 1'b0;
            end else if (tick && m_run) begin
                m_step = 1'b1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h14: begin
                        m_den = bus_wdata[5]; m_hen = bus_wdata[4];
                        m_men = bus_wdata[3]; m_aien = bus_wdata[1];
                        m_run = bus_wdata[0];
                        if (bus_wdata[2] && !fire) m_flag = 1'b0;
                    end
                    8'h15: if (!was) m_sec = bus_wdata;
                    8'h16: if (!was) m_min = bus_wdata;
                    8'h17: if (!was) m_hr = bus_wdata;
                    8'h18: if (!was) m_day = (m_day / 256) * 256 + bus_wdata;
                    8'h19: if (!was) m_day = (bus_wdata % 128) * 256 + m_day % 256;
                    8'h1A: m_amin = bus_wdata;
                    8'h1B: m_ahr = bus_wdata;
                    8'h1C: m_aday = (m_aday / 256) * 256 + bus_wdata;
                    8'h1D: m_aday = (bus_wdata % 128) * 256 + m_aday % 256;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10: irq compared against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) chk("R10 irq", int'(irq), int'(m_flag && m_aien));
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_model(logic [7:0] a, string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, int'(bus_rdata), model_rd(a));
    endtask

    task automatic rd_lit(logic [7:0] a, int exp, string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, int'(bus_rdata), exp);
        chk(req, int'(bus_rdata), model_rd(a));
    endtask

    task automatic one_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(int s, int m, int h, int d);
        wr(8'h15, 8'(s)); wr(8'h16, 8'(m)); wr(8'h17, 8'(h));
        wr(8'h18, 8'(d % 256)); wr(8'h19, 8'(d / 256));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        for (int a = 8'h14; a <= 8'h1D; a++) rd_lit(8'(a), 0, "R11 reset");
        chk("R11 irq", int'(irq), 0);

        // R6: out-of-range BCD accepted
        wr(8'h15, 8'h7A);
        rd_lit(8'h15, 8'h7A, "R6 raw load");

        // R4: stopped counter ignores ticks
        set_time('h10, 0, 0, 0);
        one_tick();
        rd_lit(8'h15, 'h10, "R4 no run");

        // R1: seconds wrap and carry
        wr(8'h14, 8'h01);
        wr(8'h15, 8'h58);
        one_tick();
        rd_lit(8'h15, 'h59, "R1 count");
        one_tick();
        rd_lit(8'h15, 'h00, "R1 wrap");
        rd_lit(8'h16, 'h01, "R1 carry");

        // R2: minute and hour carries
        set_time('h59, 'h59, 'h22, 5);
        one_tick();
        rd_lit(8'h17, 'h23, "R2 hour inc");
        rd_lit(8'h16, 'h00, "R2 min wrap");
        set_time('h59, 'h59, 'h23, 5);
        one_tick();
        rd_lit(8'h17, 'h00, "R2 hour wrap");
        rd_lit(8'h18, 6, "R2 day carry");

        // R3: day wrap and high byte layout
        set_time('h59, 'h59, 'h23, 'h7FFF);
        rd_lit(8'h19, 'h7F, "R3 high byte");
        one_tick();
        rd_lit(8'h18, 0, "R3 wrap low");
        rd_lit(8'h19, 0, "R3 wrap high");
        wr(8'h19, 8'hFF);
        rd_lit(8'h19, 'h7F, "R3 bit7 zero");

        // R5: busy for one cycle after tick
        set_time('h20, 0, 0, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; bus_addr = 8'h14;
        #1 chk("R5 busy", int'(bus_rdata[7]), 1);
        bus_addr = 8'h15;
        #1 chk("R5 old time while busy", int'(bus_rdata), 'h20);
        @(negedge clk); bus_addr = 8'h14;
        #1 chk("R5 busy drop", int'(bus_rdata[7]), 0);
        rd_lit(8'h15, 'h21, "R5 advanced");

        // R6: write during busy ignored
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        bus_addr = 8'h15; bus_wdata = 8'h33; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd_lit(8'h15, 'h22, "R6 busy write");

        // R7: minute alarm fires once
        wr(8'h1A, 8'h05);
        wr(8'h14, 8'h0B);
        set_time('h59, 'h04, 0, 0);
        one_tick();
        rd_lit(8'h14, 'h0F, "R7 flag set");
        chk("R7 irq", int'(irq), 1);
        wr(8'h14, 8'h0F);
        rd_lit(8'h14, 'h0B, "R9 clear");
        one_tick();
        rd_lit(8'h14, 'h0B, "R7 no refire");

        // R9: writing 0 keeps flag; set beats clear
        set_time('h59, 'h04, 0, 0);
        one_tick();
        wr(8'h14, 8'h0B);
        rd_lit(8'h14, 'h0F, "R9 write zero");
        wr(8'h14, 8'h0F);
        set_time('h59, 'h04, 0, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        bus_addr = 8'h14; bus_wdata = 8'h0F; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd_lit(8'h14, 'h0F, "R9 set wins");

        // R10: enable gating
        wr(8'h14, 8'h09);
        @(negedge clk);
        chk("R10 gated", int'(irq), 0);
        rd_lit(8'h14, 'h0D, "R10 flag kept");
        wr(8'h14, 8'h0F);

        // R8: no enables, no alarm
        wr(8'h14, 8'h03);
        set_time('h59, 'h04, 0, 0);
        one_tick();
        rd_lit(8'h14, 'h03, "R8 no fire");

        // R7: hour-only and day-only alarms
        wr(8'h1B, 8'h07);
        wr(8'h14, 8'h13);
        set_time('h59, 'h59, 'h06, 3);
        one_tick();
        rd_lit(8'h14, 'h17, "R7 hour alarm");
        wr(8'h14, 8'h17);
        wr(8'h1C, 8'h00); wr(8'h1D, 8'h01);
        rd_model(8'h1D, "R7 alarm day high");
        wr(8'h14, 8'h23);
        set_time('h59, 'h59, 'h23, 'h00FF);
        one_tick();
        rd_lit(8'h14, 'h27, "R7 day alarm");
        rd_model(8'h18, "R3 day low");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule